// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Output Latch

This block is an eight-pin general-purpose port for a small microcontroller core. Each pin has a storage bit, a pull-down driver that the bit controls, a weak pull-up supplied outside the block, and an input path through a two-stage synchronizer. The core writes the storage bits. It can read them back in two ways. A latch read returns the stored bits. A pin read returns the levels seen on the pins. Read-modify-write sequences use the latch read, so a pin that something outside is holding low cannot corrupt the stored value. A pin can serve as an input only while its stored bit is 1, because a 0 turns on the pull-down.

A second mode gives the pins to a multiplexed external memory bus. While an address strobe is high, the port drives the low address byte with full drive in both directions. After that it either drives a write data byte or releases all pins so that read data can come back. The sampled pin levels are offered to that bus. While this mode is active, the stored bits are frozen. They take control of the pins again as soon as the mode ends.

Top module: `qbp_port`

## Requirements
- R1: When reset is asserted, every stored bit becomes 1, rd_data becomes 0x00, both synchronizer stages become all ones, pin_oe_n reads 0xFF and pin_pu_strong reads 0x00.
- R2: When wr_en is high while alt_en is low, the stored byte takes wr_data at that clock edge. A latch read issued afterwards returns that byte.
- R3: While alt_en is low, each bit of pin_oe_n equals the matching stored bit, where 0 means the pin is pulled low and 1 means it is released. pin_pu_strong is 0x00 in this mode.
- R4: A pin read returns pin_in after two synchronizing flops. A pin whose stored bit is 1 reads 0 on the pin path when held low from outside, while the latch read still returns 1 for that bit.
- R5: rd_data is registered. It takes the selected value at the clock edge where rd_latch or rd_pin is high, and it holds its value at every edge where both are low.
- R6: When rd_latch and rd_pin are high in the same cycle, the latch read wins.
- R7: When wr_en and rd_latch are high in the same cycle, rd_data returns the stored byte as it was before that write.
- R8: While alt_en and alt_ale are both high, the pins carry alt_addr with full drive: pin_oe_n equals alt_addr and pin_pu_strong equals alt_addr.
- R9: While alt_en is high and alt_ale is low, alt_drv high drives alt_wdata in the same way. alt_drv low releases every pin, so pin_oe_n is 0xFF and pin_pu_strong is 0x00.
- R10: A write with wr_en high while alt_en is high leaves the stored byte unchanged. When alt_en falls, the pins again follow the stored byte.
- R11: alt_rdata always equals the synchronized pin levels, the same value a pin read would return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for the stored byte |
| wr_data | input | 8 | Byte to store |
| rd_latch | input | 1 | Strobe to read the stored byte |
| rd_pin | input | 1 | Strobe to read the synchronized pin levels |
| rd_data | output | 8 | Registered read result |
| alt_en | input | 1 | Hand the pins to the external memory bus |
| alt_ale | input | 1 | Address phase strobe of that bus |
| alt_drv | input | 1 | Drive alt_wdata during the data phase |
| alt_addr | input | 8 | Low address byte |
| alt_wdata | input | 8 | Write data byte |
| alt_rdata | output | 8 | Synchronized pin levels for the bus |
| pin_in | input | 8 | Levels seen on the pins |
| pin_oe_n | output | 8 | Per-bit pull-down enable, active low |
| pin_pu_strong | output | 8 | Per-bit strong pull-up enable |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a write and a latch read. The bench raises wr_en and rd_latch at the same edge and requires the pre-write byte to come back. A second latch read must then show the new byte. The second pair is a latch read and a pin read. The bench raises both strobes while an outside driver holds some pins low, so the two possible answers differ, and only the stored byte is accepted. A resistive pin model in the bench resolves the port's own pull-down, the weak pull-up and the outside drivers, so pin reads and latch reads are judged on values that really diverge.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  localparam int unsigned QBP_W = 8;

  typedef enum logic [1:0] {
    DRV_LATCH = 2'd0,
    DRV_ADDR  = 2'd1,
    DRV_DATA  = 2'd2,
    DRV_FLOAT = 2'd3
  } drv_sel_e;
endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] s1_q, s1_d;
  logic [W-1:0] s2_q, s2_d;

  always_comb begin
    s1_d = d_in;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign d_out = s2_q;

  // R4: the output repeats the input from two edges earlier
  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> d_out == $past(d_in, 2));
endmodule

// File: rtl/qbp_latch.sv
module qbp_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         freeze,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lat_q
);
  logic         lat_ce;
  logic [W-1:0] lat_d;

  always_comb begin
    lat_ce = wr_en & ~freeze;
    lat_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '1;
    else if (lat_ce) lat_q <= lat_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) a_r1_latch_ones: assert (lat_q == '1);
  end

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !freeze) |=> lat_q == $past(wr_data));

  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> lat_q == $past(lat_q));
endmodule

// File: rtl/qbp_drive.sv
module qbp_drive
  import qbp_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         alt_en,
  input  logic         alt_ale,
  input  logic         alt_drv,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] alt_addr,
  input  logic [W-1:0] alt_wdata,
  output logic [W-1:0] pin_oe_n,
  output logic [W-1:0] pin_pu_strong
);
  drv_sel_e sel;

  always_comb begin
    if (!alt_en)      sel = DRV_LATCH;
    else if (alt_ale) sel = DRV_ADDR;
    else if (alt_drv) sel = DRV_DATA;
    else              sel = DRV_FLOAT;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel)
        DRV_LATCH: begin
          pin_oe_n[i]      = lat_q[i];
          pin_pu_strong[i] = 1'b0;
        end
        DRV_ADDR: begin
          pin_oe_n[i]      = alt_addr[i];
          pin_pu_strong[i] = alt_addr[i];
        end
        DRV_DATA: begin
          pin_oe_n[i]      = alt_wdata[i];
          pin_pu_strong[i] = alt_wdata[i];
        end
        default: begin
          pin_oe_n[i]      = 1'b1;
          pin_pu_strong[i] = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/qbp_rdpath.sv
module qbp_rdpath #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_latch,
  input  logic         rd_pin,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] rd_data
);
  logic         rd_ce;
  logic [W-1:0] rd_d;

  always_comb begin
    rd_ce = rd_latch | rd_pin;
    rd_d  = rd_latch ? lat_q : pin_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_ce) rd_data <= rd_d;
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_latch && !rd_pin) |=> $stable(rd_data));

  a_r6_latch_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch |=> rd_data == $past(lat_q));

  a_r4_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pin && !rd_latch) |=> rd_data == $past(pin_s));
endmodule

// File: rtl/qbp_port.sv
module qbp_port
  import qbp_pkg::*;
#(
  parameter int unsigned W = QBP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_latch,
  input  logic         rd_pin,
  output logic [W-1:0] rd_data,
  input  logic         alt_en,
  input  logic         alt_ale,
  input  logic         alt_drv,
  input  logic [W-1:0] alt_addr,
  input  logic [W-1:0] alt_wdata,
  output logic [W-1:0] alt_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_oe_n,
  output logic [W-1:0] pin_pu_strong
);
  logic [W-1:0] lat_q;
  logic [W-1:0] pin_s;

  qbp_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pin_in),
    .d_out (pin_s)
  );

  qbp_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .freeze  (alt_en),
    .wr_data (wr_data),
    .lat_q   (lat_q)
  );

  qbp_drive #(.W(W)) u_drive (
    .alt_en        (alt_en),
    .alt_ale       (alt_ale),
    .alt_drv       (alt_drv),
    .lat_q         (lat_q),
    .alt_addr      (alt_addr),
    .alt_wdata     (alt_wdata),
    .pin_oe_n      (pin_oe_n),
    .pin_pu_strong (pin_pu_strong)
  );

  qbp_rdpath #(.W(W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_latch (rd_latch),
    .rd_pin   (rd_pin),
    .lat_q    (lat_q),
    .pin_s    (pin_s),
    .rd_data  (rd_data)
  );

  assign alt_rdata = pin_s;

  // R8: no bit may pull low and strongly high at once
  a_r8_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu_strong & ~pin_oe_n) == '0);

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_en && !alt_ale && !alt_drv) |-> (pin_oe_n == '1 && pin_pu_strong == '0));

  a_r3_gpio_no_strong: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_en |-> pin_pu_strong == '0);
endmodule

// File: tb/qbp_port_bench.sv
module qbp_pin_model #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] oe_n,
  input  logic [W-1:0] pu_strong,
  input  logic [W-1:0] ext_en,
  input  logic [W-1:0] ext_val,
  output logic [W-1:0] level
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      if (!oe_n[i])          level[i] = 1'b0;      // own pull-down wins
      else if (pu_strong[i]) level[i] = 1'b1;      // strong high
      else if (ext_en[i])    level[i] = ext_val[i]; // outside driver beats weak pull-up
      else                   level[i] = 1'b1;      // weak pull-up
    end
  end
endmodule

module qbp_port_bench;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, rd_latch, rd_pin;
  logic [W-1:0] wr_data, rd_data;
  logic         alt_en, alt_ale, alt_drv;
  logic [W-1:0] alt_addr, alt_wdata, alt_rdata;
  logic [W-1:0] pin_in, pin_oe_n, pin_pu_strong;
  logic [W-1:0] ext_en, ext_val;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic         pend;

  always #5 clk = ~clk;

  qbp_port u_qbp_port (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .rd_data(rd_data),
    .alt_en(alt_en), .alt_ale(alt_ale), .alt_drv(alt_drv),
    .alt_addr(alt_addr), .alt_wdata(alt_wdata), .alt_rdata(alt_rdata),
    .pin_in(pin_in), .pin_oe_n(pin_oe_n), .pin_pu_strong(pin_pu_strong)
  );

  qbp_pin_model #(.W(W)) u_pins (
    .oe_n(pin_oe_n), .pu_strong(pin_pu_strong),
    .ext_en(ext_en), .ext_val(ext_val), .level(pin_in)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one read result per strobed edge
  always_ff @(posedge clk) pend <= (rd_latch | rd_pin) & rst_n;

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard actual=%02h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input bit lt, input bit pn, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    rd_latch = lt; rd_pin = pn;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_latch = 1'b0; rd_pin = 1'b0;
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    wr_en = 0; rd_latch = 0; rd_pin = 0; wr_data = '0;
    alt_en = 0; alt_ale = 0; alt_drv = 0; alt_addr = '0; alt_wdata = '0;
    ext_en = '0; ext_val = '0;
    #2 rst_n = 1'b0;
    idle(3);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 oe_n", pin_oe_n, 8'hFF);
    check("R1 pu_strong", pin_pu_strong, 8'h00);
    check("R1 sync", alt_rdata, 8'hFF);
    rst_n = 1'b1;
    idle(2);
    rd(1, 0, 8'hFF, "R1 latch after reset");

    wr(8'hA5);
    check("R3 oe_n follows latch", pin_oe_n, 8'hA5);
    check("R3 no strong pull-up", pin_pu_strong, 8'h00);
    rd(1, 0, 8'hA5, "R2 latch read");
    idle(3);
    rd(0, 1, 8'hA5, "R4 pin read own drive");

    wr(8'hFF);
    ext_en = 8'h09; ext_val = 8'h00;
    idle(3);
    rd(0, 1, 8'hF6, "R4 pin read external low");
    rd(1, 0, 8'hFF, "R4 latch unaffected by pins");

    // read-modify-write on the latch path: clear bit 7
    rd(1, 0, 8'hFF, "R4 rmw fetch");
    wr(8'hFF & 8'h7F);
    rd(1, 0, 8'h7F, "R4 rmw result");
    idle(3);
    rd(0, 1, 8'h76, "R4 pin after rmw");

    rd(1, 1, 8'h7F, "R6 both strobes");

    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'h3C; rd_latch = 1'b1;
    exp_q.push_back(8'h7F); tag_q.push_back("R7 write and read same cycle");
    @(negedge clk);
    wr_en = 1'b0; rd_latch = 1'b0;
    rd(1, 0, 8'h3C, "R7 new value next read");

    ext_en = '0;
    idle(4);
    check("R5 rd_data held", rd_data, 8'h3C);

    @(negedge clk);
    alt_en = 1; alt_ale = 1; alt_addr = 8'h5A;
    #1;
    check("R8 addr oe_n", pin_oe_n, 8'h5A);
    check("R8 addr strong", pin_pu_strong, 8'h5A);
    @(negedge clk);
    alt_ale = 0; alt_drv = 1; alt_wdata = 8'hC3;
    #1;
    check("R9 data oe_n", pin_oe_n, 8'hC3);
    check("R9 data strong", pin_pu_strong, 8'hC3);
    @(negedge clk);
    alt_drv = 0;
    wr_en = 1'b1; wr_data = 8'h11;
    #1;
    check("R9 release oe_n", pin_oe_n, 8'hFF);
    check("R9 release strong", pin_pu_strong, 8'h00);
    ext_en = 8'hFF; ext_val = 8'h96;
    @(negedge clk);
    wr_en = 1'b0;
    idle(3);
    check("R11 alt read data", alt_rdata, 8'h96);
    ext_en = '0;
    alt_en = 0;
    #1;
    check("R10 pins back to latch", pin_oe_n, 8'h3C);
    rd(1, 0, 8'h3C, "R10 write ignored in alt mode");
    idle(3);
    check("R11 alt_rdata tracks pins", alt_rdata, 8'h3C);
    rd(0, 1, 8'h3C, "R11 pin read matches");

    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule